// File: doc/BRIEF.md
# Quadrature Phase-Counting Timer Channel

This block is one timer channel whose 16-bit counter is clocked by the two phases of an incremental encoder rather than by a prescaled internal clock. The two phase inputs are synchronized and compared against their previous sampled state. Each legal transition moves the counter one step up or one step down, which gives four counts per encoder cycle. A transition in which both phases change between two samples is treated as a glitch and is not counted.

Around the counter sit the parts of a full timer channel that remain in use in this mode. There are general registers that act as either compare or capture registers. A selectable clear source can reset the counter when it reaches a compare value. There are sticky overflow and underflow flags, a live direction bit, and per-flag interrupt enables. Software configures everything through a plain write port and a combinational read port. It starts counting by selecting phase mode and setting the start bit.

Top module: `quad_timer`

## Requirements
- R1: Phase state index is 0 for {A,B}=00, 1 for 10, 2 for 11 and 3 for 01. A move from index i to index (i+1) mod 4 adds one to the counter, wrapping from 0xFFFF to 0. The new count is visible in the third clock after the pins change.
- R2: A move from index i to (i+3) mod 4 subtracts one, wrapping from 0 to 0xFFFF. A move to (i+2) mod 4, where both phases change, leaves the counter unchanged, and so does no move.
- R3: The counter steps only while control bit 0 (start) is 1 and control bits [2:1] (mode) equal 01. Control bits [10:8] (prescaler) and [12:11] (clock edge) have no effect on counting.
- R4: An up step from 0xFFFF sets the sticky overflow flag, status bit 4.
- R5: A down step from 0 sets the sticky underflow flag, status bit 5.
- R6: Status bit 7 reads 1 after an up step and 0 after a down step. Its reset value is 1.
- R7: With I/O control bit k at 0, general register k is a compare register. A count step whose result equals it sets status bit k.
- R8: With control bits [5:4] equal to k+1, the next count step taken while the counter equals compare register k loads 0 instead of stepping. That step sets no overflow or underflow.
- R9: With I/O control bit k at 1, general register k captures the counter on a capture-pin edge and sets status bit k. I/O control bits [9:8] select the edge: 0 means rising, 1 means falling, 2 or 3 means both. If a count step falls in the same cycle, the pre-step value is captured.
- R10: Writing the status register clears every flag whose written bit is 0 and leaves flags written with 1 unchanged. A flag event in the same cycle wins over the clear.
- R11: irq_gr[k] is high while status bit k and enable bit k are both set. irq_ovf is tied in the same way to enable bit 4 and irq_unf to enable bit 5.
- R12: Registers sit at these addresses: 0 control, 1 I/O control, 2 interrupt enable, 3 status, 4 counter, and 5+k general register k. A counter write takes priority over a count step in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| phase_a | input | 1 | Encoder phase A, asynchronous |
| phase_b | input | 1 | Encoder phase B, asynchronous |
| cap_in | input | 1 | Capture trigger, asynchronous |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register write address |
| wr_data | input | CNT_W | Register write data |
| rd_addr | input | 3 | Register read address |
| rd_data | output | CNT_W | Read data, combinational from rd_addr |
| irq_gr | output | NUM_GR | Per general-register interrupt request |
| irq_ovf | output | 1 | Overflow interrupt request |
| irq_unf | output | 1 | Underflow interrupt request |

## Verification
The capture path and the phase path use synchronizers of equal depth. A capture edge and a phase step driven on the same clock therefore reach the channel in the same cycle. The bench makes both changes at one falling edge and expects the general register to hold the count from before the step while the counter moves on by one. The second collision is a clear step taken at 0xFFFF. It must load zero and leave the overflow flag clear, and the bench judges this by reading both the counter and the status register.

// File: rtl/qt_pkg.sv
package qt_pkg;
  localparam int ADDR_W = 3;

  localparam logic [ADDR_W-1:0] ADR_CTRL = 3'd0;
  localparam logic [ADDR_W-1:0] ADR_IOC  = 3'd1;
  localparam logic [ADDR_W-1:0] ADR_IEN  = 3'd2;
  localparam logic [ADDR_W-1:0] ADR_STAT = 3'd3;
  localparam logic [ADDR_W-1:0] ADR_CNT  = 3'd4;
  localparam int               ADR_GR0  = 5;

  localparam int BIT_OVF = 4;
  localparam int BIT_UNF = 5;
  localparam int BIT_DIR = 7;

  typedef enum logic [1:0] {
    MODE_PLAIN = 2'b00,
    MODE_PHASE = 2'b01,
    MODE_RSV2  = 2'b10,
    MODE_RSV3  = 2'b11
  } mode_e;

  typedef enum logic [1:0] {
    CAP_RISE = 2'd0,
    CAP_FALL = 2'd1,
    CAP_BOTH = 2'd2,
    CAP_ANY  = 2'd3
  } cap_edge_e;
endpackage

// File: rtl/qt_sync.sv
module qt_sync #(
  parameter int W      = 1,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stage_q [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < STAGES; i++) stage_q[i] <= '0;
    end else begin
      stage_q[0] <= d;
      for (int i = 1; i < STAGES; i++) stage_q[i] <= stage_q[i-1];
    end
  end

  assign q = stage_q[STAGES-1];
endmodule

// File: rtl/qt_phase_dec.sv
module qt_phase_dec #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pha,
  input  logic phb,
  output logic step_up,
  output logic step_dn
);
  logic [1:0] ab_s;
  logic [1:0] idx_cur, idx_prev, delta;

  qt_sync #(.W(2), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .d({pha, phb}), .q(ab_s)
  );

  // Gray order 00 -> 10 -> 11 -> 01 maps to index {b, a^b}
  assign idx_cur = {ab_s[0], ab_s[1] ^ ab_s[0]};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) idx_prev <= 2'd0;
    else        idx_prev <= idx_cur;
  end

  assign delta   = idx_cur - idx_prev;
  assign step_up = (delta == 2'd1);
  assign step_dn = (delta == 2'd3);
endmodule

// File: rtl/qt_counter.sv
module qt_counter #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         en,
  input  logic         up,
  input  logic         dn,
  input  logic         clr,
  input  logic         load,
  input  logic [W-1:0] load_val,
  output logic [W-1:0] cnt,
  output logic [W-1:0] cnt_nx,
  output logic         stepped,
  output logic         ovf_evt,
  output logic         unf_evt,
  output logic         dir
);
  localparam logic [W-1:0] MAX_V = {W{1'b1}};

  assign stepped = !load && en && (up || dn);

  always_comb begin
    cnt_nx  = cnt;
    ovf_evt = 1'b0;
    unf_evt = 1'b0;
    if (load) begin
      cnt_nx = load_val;
    end else if (stepped) begin
      if (clr) begin
        cnt_nx = '0;
      end else if (up) begin
        cnt_nx  = cnt + 1'b1;
        ovf_evt = (cnt == MAX_V);
      end else begin
        cnt_nx  = cnt - 1'b1;
        unf_evt = (cnt == '0);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
      dir <= 1'b1;
    end else begin
      cnt <= cnt_nx;
      if (stepped) dir <= up;
    end
  end
endmodule

// File: rtl/quad_timer.sv
module quad_timer
  import qt_pkg::*;
#(
  parameter int CNT_W       = 16,
  parameter int NUM_GR      = 2,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              phase_a,
  input  logic              phase_b,
  input  logic              cap_in,
  input  logic              wr_en,
  input  logic [2:0]        wr_addr,
  input  logic [CNT_W-1:0]  wr_data,
  input  logic [2:0]        rd_addr,
  output logic [CNT_W-1:0]  rd_data,
  output logic [NUM_GR-1:0] irq_gr,
  output logic              irq_ovf,
  output logic              irq_unf
);
  localparam int CLR_W = 2;

  logic [CNT_W-1:0] ctrl_q, ioc_q, ien_q;
  logic [CNT_W-1:0] cnt_q, cnt_nx, stat_v;
  logic [CNT_W-1:0] gr_q [NUM_GR];
  logic [NUM_GR-1:0] flag_gr, hit;
  logic ovf_q, unf_q, dir_q;
  logic dec_up, dec_dn, run, stepped, ovf_evt, unf_evt;
  logic cnt_wr, stat_wr, clr_hit;
  logic cap_s, cap_prev, cap_rise, cap_fall, cap_evt;
  mode_e     mode;
  cap_edge_e cap_sel;
  logic [CLR_W-1:0] clr_sel;

  assign mode    = mode_e'(ctrl_q[2:1]);
  assign run     = ctrl_q[0] && (mode == MODE_PHASE);
  assign clr_sel = ctrl_q[5:4];
  assign cap_sel = cap_edge_e'(ioc_q[9:8]);
  assign cnt_wr  = wr_en && (wr_addr == ADR_CNT);
  assign stat_wr = wr_en && (wr_addr == ADR_STAT);

  qt_phase_dec #(.SYNC_STAGES(SYNC_STAGES)) u_dec (
    .clk(clk), .rst_n(rst_n), .pha(phase_a), .phb(phase_b),
    .step_up(dec_up), .step_dn(dec_dn)
  );

  assign clr_hit = run && (dec_up || dec_dn) && (|hit);

  qt_counter #(.W(CNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .en(run), .up(dec_up), .dn(dec_dn),
    .clr(|hit), .load(cnt_wr), .load_val(wr_data),
    .cnt(cnt_q), .cnt_nx(cnt_nx), .stepped(stepped),
    .ovf_evt(ovf_evt), .unf_evt(unf_evt), .dir(dir_q)
  );

  qt_sync #(.W(1), .STAGES(SYNC_STAGES)) u_cap_sync (
    .clk(clk), .rst_n(rst_n), .d(cap_in), .q(cap_s)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cap_prev <= 1'b0;
    else        cap_prev <= cap_s;
  end

  assign cap_rise = cap_s & ~cap_prev;
  assign cap_fall = ~cap_s & cap_prev;

  always_comb begin
    case (cap_sel)
      CAP_RISE: cap_evt = cap_rise;
      CAP_FALL: cap_evt = cap_fall;
      default:  cap_evt = cap_rise | cap_fall;
    endcase
  end

  // configuration registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0;
      ioc_q  <= '0;
      ien_q  <= '0;
    end else if (wr_en) begin
      if (wr_addr == ADR_CTRL) ctrl_q <= wr_data;
      if (wr_addr == ADR_IOC)  ioc_q  <= wr_data;
      if (wr_addr == ADR_IEN)  ien_q  <= wr_data;
    end
  end

  // wrap flags: set wins over a clearing write
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ovf_q <= 1'b0;
      unf_q <= 1'b0;
    end else begin
      ovf_q <= ovf_evt | (ovf_q & ~(stat_wr & ~wr_data[BIT_OVF]));
      unf_q <= unf_evt | (unf_q & ~(stat_wr & ~wr_data[BIT_UNF]));
    end
  end

  for (genvar k = 0; k < NUM_GR; k++) begin : g_gr
    logic [CNT_W-1:0] gr_r;
    logic             flag_r, wr_gr, is_cap, match_evt, cap_k;

    assign is_cap    = ioc_q[k];
    assign wr_gr     = wr_en && (int'(wr_addr) == ADR_GR0 + k);
    assign match_evt = stepped && !is_cap && (cnt_nx == gr_r);
    assign cap_k     = cap_evt && is_cap;
    assign hit[k]    = (int'(clr_sel) == k + 1) && !is_cap && (cnt_q == gr_r);

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        gr_r   <= {CNT_W{1'b1}};
        flag_r <= 1'b0;
      end else begin
        if (wr_gr)      gr_r <= wr_data;
        else if (cap_k) gr_r <= cnt_q;
        flag_r <= match_evt | cap_k | (flag_r & ~(stat_wr & ~wr_data[k]));
      end
    end

    assign gr_q[k]    = gr_r;
    assign flag_gr[k] = flag_r;
    assign irq_gr[k]  = flag_r & ien_q[k];
  end

  assign irq_ovf = ovf_q & ien_q[BIT_OVF];
  assign irq_unf = unf_q & ien_q[BIT_UNF];

  always_comb begin
    stat_v = '0;
    for (int k = 0; k < NUM_GR; k++) stat_v[k] = flag_gr[k];
    stat_v[BIT_OVF] = ovf_q;
    stat_v[BIT_UNF] = unf_q;
    stat_v[BIT_DIR] = dir_q;
  end

  always_comb begin
    rd_data = '0;
    case (rd_addr)
      ADR_CTRL: rd_data = ctrl_q;
      ADR_IOC:  rd_data = ioc_q;
      ADR_IEN:  rd_data = ien_q;
      ADR_STAT: rd_data = stat_v;
      ADR_CNT:  rd_data = cnt_q;
      default: begin
        for (int k = 0; k < NUM_GR; k++)
          if (int'(rd_addr) == ADR_GR0 + k) rd_data = gr_q[k];
      end
    endcase
  end
endmodule

// File: rtl/quad_timer_chk.sv
module quad_timer_chk #(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             run,
  input logic             step_up,
  input logic             step_dn,
  input logic             cnt_wr,
  input logic             clr_hit,
  input logic [CNT_W-1:0] cnt,
  input logic             ovf,
  input logic             unf,
  input logic             dir
);
  localparam logic [CNT_W-1:0] MAX_V = {CNT_W{1'b1}};

  AST_ONE_DIRECTION: assert property (@(posedge clk) disable iff (!rst_n)
    !(step_up && step_dn)); // R2

  AST_UP_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (run && step_up && !cnt_wr && !clr_hit) |=> (cnt == $past(cnt) + 1'b1)); // R1

  AST_STOPPED_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && !cnt_wr) |=> $stable(cnt)); // R3

  AST_OVERFLOW_SET: assert property (@(posedge clk) disable iff (!rst_n)
    (run && step_up && !cnt_wr && !clr_hit && cnt == MAX_V) |=> ovf); // R4

  AST_UNDERFLOW_SET: assert property (@(posedge clk) disable iff (!rst_n)
    (run && step_dn && !cnt_wr && !clr_hit && cnt == '0) |=> unf); // R5

  AST_DIR_DOWN: assert property (@(posedge clk) disable iff (!rst_n)
    (run && step_dn && !cnt_wr) |=> !dir); // R6

  AST_CLEAR_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_hit && !cnt_wr) |=> (cnt == '0)); // R8
endmodule

bind quad_timer quad_timer_chk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .run(run), .step_up(dec_up), .step_dn(dec_dn),
  .cnt_wr(cnt_wr), .clr_hit(clr_hit), .cnt(cnt_q), .ovf(ovf_q),
  .unf(unf_q), .dir(dir_q)
);

// File: tb/tb_quad_timer.sv
`timescale 1ns/1ps
module tb_quad_timer;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        phase_a = 1'b0, phase_b = 1'b0, cap_in = 1'b0;
  logic        wr_en = 1'b0;
  logic [2:0]  wr_addr = '0, rd_addr = '0;
  logic [15:0] wr_data = '0;
  logic [15:0] rd_data;
  logic [1:0]  irq_gr;
  logic        irq_ovf, irq_unf;

  int n_cmp = 0;
  int n_bad = 0;
  int cur = 0;

  quad_timer dut (
    .clk(clk), .rst_n(rst_n), .phase_a(phase_a), .phase_b(phase_b),
    .cap_in(cap_in), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data), .irq_gr(irq_gr),
    .irq_ovf(irq_ovf), .irq_unf(irq_unf)
  );

  always #10 clk = ~clk;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [15:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [15:0] v);
    rd_addr = a;
    #1;
    v = rd_data;
  endtask

  task automatic set_ph(input int idx);
    @(negedge clk);
    phase_a = (idx == 1 || idx == 2);
    phase_b = (idx >= 2);
    cur = idx;
    repeat (3) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic up1();   set_ph((cur + 1) % 4); endtask
  task automatic down1(); set_ph((cur + 3) % 4); endtask

  initial begin
    #4_000_000;
    n_bad++;
    $display("FAIL watchdog expired");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    logic [15:0] v, c0, c1, exp;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    rd(3'd4, v); chk("R12 reset count", v, 16'h0000);
    rd(3'd3, v); chk("R6 reset status", v, 16'h0080);
    chk("R11 reset irq", {irq_gr, irq_ovf, irq_unf}, 4'b0000);

    // R1 R2 exhaustive transition sweep
    wr(3'd0, 16'h0003);
    wr(3'd4, 16'h0100);
    for (int i = 0; i < 4; i++) begin
      for (int j = 0; j < 4; j++) begin
        set_ph(i);
        rd(3'd4, c0);
        set_ph(j);
        rd(3'd4, c1);
        case ((j - i + 4) % 4)
          1: exp = c0 + 16'd1;
          3: exp = c0 - 16'd1;
          default: exp = c0;
        endcase
        chk("R1/R2 transition step", c1, exp);
        if ((j - i + 4) % 4 == 1) begin
          rd(3'd3, v); chk("R6 dir up", v[7], 1'b1);
        end
        if ((j - i + 4) % 4 == 3) begin
          rd(3'd3, v); chk("R6 dir down", v[7], 1'b0);
        end
      end
    end

    // R3 start and mode gating; ignored fields
    wr(3'd4, 16'h0200);
    wr(3'd0, 16'h0002);
    up1(); rd(3'd4, v); chk("R3 no start", v, 16'h0200);
    wr(3'd0, 16'h0001);
    up1(); rd(3'd4, v); chk("R3 wrong mode", v, 16'h0200);
    wr(3'd0, 16'h1F03);
    up1(); rd(3'd4, v); chk("R3 prescaler/edge ignored", v, 16'h0201);
    down1(); rd(3'd4, v); chk("R3 down with fields set", v, 16'h0200);
    wr(3'd0, 16'h0003);

    // R4 R5 wrap flags and R10 clearing
    wr(3'd3, 16'h0000);
    wr(3'd4, 16'hFFFE);
    up1(); rd(3'd3, v); chk("R4 no ovf before wrap", v[4], 1'b0);
    up1(); rd(3'd4, v); chk("R1 wrap up", v, 16'h0000);
    rd(3'd3, v); chk("R4 ovf set", v[4], 1'b1);
    down1(); rd(3'd4, v); chk("R2 wrap down", v, 16'hFFFF);
    rd(3'd3, v); chk("R5 unf set", v[5], 1'b1);
    chk("R4 ovf sticky", v[4], 1'b1);
    wr(3'd2, 16'h0010);
    chk("R11 irq_ovf", irq_ovf, 1'b1);
    chk("R11 irq_unf masked", irq_unf, 1'b0);
    wr(3'd3, 16'h0010);
    rd(3'd3, v); chk("R10 write1 keeps ovf", v[4], 1'b1);
    chk("R10 write0 clears unf", v[5], 1'b0);
    wr(3'd2, 16'h0000);
    chk("R11 irq_ovf disabled", irq_ovf, 1'b0);
    wr(3'd3, 16'h0000);
    rd(3'd3, v); chk("R10 ovf cleared", v[5:4], 2'b00);

    // R7 compare sweep
    wr(3'd1, 16'h0000);
    wr(3'd2, 16'h0001);
    for (int g = 2; g < 8; g++) begin
      wr(3'd5, 16'(g));
      wr(3'd4, 16'(g - 2));
      wr(3'd3, 16'h0000);
      up1(); rd(3'd3, v); chk("R7 before match", v[0], 1'b0);
      up1(); rd(3'd3, v); chk("R7 match flag", v[0], 1'b1);
      chk("R11 irq_gr0", irq_gr[0], 1'b1);
    end
    wr(3'd2, 16'h0000);

    // R8 clear on compare 0, up and down, and at 0xFFFF
    wr(3'd0, 16'h0013);
    wr(3'd5, 16'h0005);
    wr(3'd4, 16'h0004);
    up1(); rd(3'd4, v); chk("R8 reach compare", v, 16'h0005);
    up1(); rd(3'd4, v); chk("R8 clear on up step", v, 16'h0000);
    wr(3'd4, 16'h0005);
    down1(); rd(3'd4, v); chk("R8 clear on down step", v, 16'h0000);
    wr(3'd5, 16'hFFFF);
    wr(3'd4, 16'hFFFF);
    wr(3'd3, 16'h0000);
    up1(); rd(3'd4, v); chk("R8 clear at max", v, 16'h0000);
    rd(3'd3, v); chk("R8 no ovf on clear", v[4], 1'b0);
    wr(3'd0, 16'h0003);

    // R9 capture edge sweep on GR1
    wr(3'd1, 16'h0002);
    for (int s = 0; s < 3; s++) begin
      for (int t = 0; t < 2; t++) begin
        wr(3'd1, 16'h0002 | 16'(s << 8));
        wr(3'd6, 16'hAAAA);
        wr(3'd4, 16'(16'h0200 + s * 16 + t));
        wr(3'd3, 16'h0000);
        @(negedge clk); cap_in = (t == 0);
        repeat (3) @(posedge clk);
        @(negedge clk);
        rd(3'd6, v);
        if ((s == 0 && t == 0) || (s == 1 && t == 1) || s == 2)
          exp = 16'(16'h0200 + s * 16 + t);
        else
          exp = 16'hAAAA;
        chk("R9 capture edge select", v, exp);
        rd(3'd3, v); chk("R9 capture flag", v[1], exp != 16'hAAAA);
      end
    end

    // R9 capture coincident with an up step
    wr(3'd1, 16'h0002);
    wr(3'd4, 16'h0070);
    @(negedge clk);
    cap_in = 1'b1;
    cur = (cur + 1) % 4;
    phase_a = (cur == 1 || cur == 2);
    phase_b = (cur >= 2);
    repeat (3) @(posedge clk);
    @(negedge clk);
    rd(3'd6, v); chk("R9 coincident capture pre-step", v, 16'h0070);
    rd(3'd4, v); chk("R9 coincident count stepped", v, 16'h0071);

    // R12 write priority over a step in the same cycle
    @(negedge clk);
    cur = (cur + 1) % 4;
    phase_a = (cur == 1 || cur == 2);
    phase_b = (cur >= 2);
    @(posedge clk); @(posedge clk);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = 3'd4; wr_data = 16'h1234;
    @(negedge clk);
    wr_en = 1'b0;
    rd(3'd4, v); chk("R12 write beats step", v, 16'h1234);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule